// File: doc/BRIEF.md
# Descriptor ring queue state

This block keeps the configuration and pointer state of one circular queue in a network interface: a 64-bit ring base address, the log2 of the ring size with an active flag, a target index with an arm flag, and the head and tail pointers that software writes. Software reaches these through a simple register write port and reads the pointers and flag words back on a registered read port.

Beside the software pointers the block keeps two issued-position counters. The fetch counter moves on each accepted fetch step and marks how far the queue has been consumed. The write counter moves on each accepted write step and marks how far it has been produced. Empty compares the software head with the fetch counter. Full compares the write counter with the software tail, using modular 16-bit subtraction. For each counter the block presents the memory address of the slot it points at. The entry size is picked by a parameter: descriptor 16 bytes, completion 32, event 32.

Top module: `descRingState`

## Requirements
- R1: After reset every pointer, counter, flag, base and size field is zero, so `empty` is 1, `full` is 0, `active` and `armed` are 0, both slot addresses are 0 and every readable word is 0.
- R2: A write to offset 0x00 replaces base bits 31:0 only, and a write to offset 0x04 replaces base bits 63:32 only.
- R3: A write to offset 0x08 stores data bits 7:0 as the log2 ring size and sets `active` to data bit 31; a read of 0x08 returns the log size in bits 7:0 and `active` in bit 31, other bits zero.
- R4: A write to offset 0x0C stores data bits 7:0 as the target index and sets `armed` when data bit 31 is 1; a write with bit 31 at 0 leaves `armed` unchanged; a read of 0x0C returns the index in bits 7:0 and `armed` in bit 31.
- R5: Writes to 0x10 and 0x14 load the software head and tail from data bits 15:0; reads of 0x10 and 0x14 return them zero-extended; a read returns its word on `rdData` one cycle after `rdEn`, and an unmapped offset reads as zero.
- R6: `empty` is 1 exactly when the software head equals the fetch counter; a `fetchStep` advances the fetch counter by one modulo 2^16 only when `empty` is 0, and is ignored otherwise.
- R7: `full` is 1 exactly when (write counter − software tail) mod 2^16 is at least 2^log; with log size 16 or more the queue is never full; a `writeStep` advances the write counter only when `full` is 0.
- R8: `fetchAddr` and `writeAddr` equal base + (counter AND (2^log − 1)) × 16 modulo 2^64 for the default descriptor entry size, the mask being all ones when the log size is 16 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write byte offset |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 8 | Register read byte offset |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| fetchStep | input | 1 | Request to advance the fetch counter |
| writeStep | input | 1 | Request to advance the write counter |
| empty | output | 1 | Software head equals fetch counter |
| full | output | 1 | Write counter a full ring ahead of software tail |
| active | output | 1 | Active flag from the log-size word |
| armed | output | 1 | Sticky arm flag from the index word |
| fetchAddr | output | 64 | Slot address of the fetch counter |
| writeAddr | output | 64 | Slot address of the write counter |

## Verification
The address-stability properties assume no register write lands in the same cycle as the step under test, because a write to the base or size fields may move a slot address in that same cycle. The stimulus issues register writes and step requests only in separate cycles, so every ignored step leaves its address where it was. The sweeps run with small log sizes, which lets the write counter reach full within a few steps. Placing the software tail just below the 16-bit wrap makes the modular fill level differ from a plain difference.

// File: rtl/ringPkg.sv
package ringPkg;

  typedef enum logic [1:0] {
    ENTRY_DESC  = 2'd0,
    ENTRY_CPL   = 2'd1,
    ENTRY_EVENT = 2'd2
  } entryKind_t;

  function automatic int entryBytes(entryKind_t kind);
    case (kind)
      ENTRY_DESC:  return 16;
      ENTRY_CPL:   return 32;
      ENTRY_EVENT: return 32;
      default:     return 16;
    endcase
  endfunction

  localparam logic [7:0] OFS_BASE_LO = 8'h00;
  localparam logic [7:0] OFS_BASE_HI = 8'h04;
  localparam logic [7:0] OFS_LOG     = 8'h08;
  localparam logic [7:0] OFS_INDEX   = 8'h0C;
  localparam logic [7:0] OFS_HEAD    = 8'h10;
  localparam logic [7:0] OFS_TAIL    = 8'h14;

  localparam int ACTIVE_BIT = 31;
  localparam int ARM_BIT    = 31;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_LOG   = 3'd1,
    SEL_INDEX = 3'd2,
    SEL_HEAD  = 3'd3,
    SEL_TAIL  = 3'd4
  } readSel_t;

  typedef struct packed {
    logic     loadBaseLo;
    logic     loadBaseHi;
    logic     loadLog;
    logic     loadIndex;
    logic     loadHead;
    logic     loadTail;
    logic     stepFetch;
    logic     stepWrite;
    logic     readEn;
    readSel_t readSel;
  } ringStrobe_t;

endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringPkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] rdAddr,
  input  logic              fetchStep,
  input  logic              writeStep,
  input  logic              isEmpty,
  input  logic              isFull,
  output ringStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wrAddr)
        REG_AW'(OFS_BASE_LO): strobe.loadBaseLo = 1'b1;
        REG_AW'(OFS_BASE_HI): strobe.loadBaseHi = 1'b1;
        REG_AW'(OFS_LOG):     strobe.loadLog    = 1'b1;
        REG_AW'(OFS_INDEX):   strobe.loadIndex  = 1'b1;
        REG_AW'(OFS_HEAD):    strobe.loadHead   = 1'b1;
        REG_AW'(OFS_TAIL):    strobe.loadTail   = 1'b1;
        default: ;
      endcase
    end
    strobe.stepFetch = fetchStep & ~isEmpty;
    strobe.stepWrite = writeStep & ~isFull;
    strobe.readEn    = rdEn;
    case (rdAddr)
      REG_AW'(OFS_LOG):   strobe.readSel = SEL_LOG;
      REG_AW'(OFS_INDEX): strobe.readSel = SEL_INDEX;
      REG_AW'(OFS_HEAD):  strobe.readSel = SEL_HEAD;
      REG_AW'(OFS_TAIL):  strobe.readSel = SEL_TAIL;
      default:            strobe.readSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/ringDatapath.sv
module ringDatapath
  import ringPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PTR_W       = 16,
  parameter int LOG_W       = 8,
  parameter int ENTRY_BYTES = 16,
  localparam int ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ringStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              isEmpty,
  output logic              isFull,
  output logic              active,
  output logic              armed,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] writeAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_CNT = 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [LOG_W-1:0]  logSize;
  logic [LOG_W-1:0]  targetIndex;
  logic [PTR_W-1:0]  swHead;
  logic [PTR_W-1:0]  swTail;
  logic [PTR_W-1:0]  issuedCnt [NUM_CNT];
  logic [ADDR_W-1:0] slotAddr  [NUM_CNT];

  logic              sizeFits;
  logic [PTR_W-1:0]  ringSize;
  logic [PTR_W-1:0]  slotMask;
  logic [PTR_W-1:0]  fillLevel;
  logic [DATA_W-1:0] readWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr    <= '0;
      logSize     <= '0;
      active      <= 1'b0;
      targetIndex <= '0;
      armed       <= 1'b0;
      swHead      <= '0;
      swTail      <= '0;
    end else begin
      if (strobe.loadBaseLo) baseAddr[DATA_W-1:0]      <= wrData;
      if (strobe.loadBaseHi) baseAddr[ADDR_W-1:DATA_W] <= wrData;
      if (strobe.loadLog) begin
        logSize <= wrData[LOG_W-1:0];
        active  <= wrData[ACTIVE_BIT];
      end
      if (strobe.loadIndex) begin
        targetIndex <= wrData[LOG_W-1:0];
        armed       <= armed | wrData[ARM_BIT];
      end
      if (strobe.loadHead) swHead <= wrData[PTR_W-1:0];
      if (strobe.loadTail) swTail <= wrData[PTR_W-1:0];
    end
  end

  // counter 0 follows consumption, counter 1 follows production
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuedCnt[0] <= '0;
      issuedCnt[1] <= '0;
    end else begin
      if (strobe.stepFetch) issuedCnt[0] <= issuedCnt[0] + 1'b1;
      if (strobe.stepWrite) issuedCnt[1] <= issuedCnt[1] + 1'b1;
    end
  end

  always_comb begin
    sizeFits  = logSize < LOG_W'(PTR_W);
    ringSize  = PTR_W'(1) << logSize;
    slotMask  = sizeFits ? (ringSize - 1'b1) : '1;
    fillLevel = issuedCnt[1] - swTail;
    isEmpty   = (swHead == issuedCnt[0]);
    isFull    = sizeFits && (fillLevel >= ringSize);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gSlot
    logic [PTR_W-1:0] slotIdx;
    assign slotIdx     = issuedCnt[g] & slotMask;
    assign slotAddr[g] = baseAddr + ADDR_W'(slotIdx) * ADDR_W'(ENTRY_BYTES);
  end

  assign fetchAddr = slotAddr[0];
  assign writeAddr = slotAddr[1];

  always_comb begin
    readWord = '0;
    case (strobe.readSel)
      SEL_LOG: begin
        readWord[LOG_W-1:0]  = logSize;
        readWord[ACTIVE_BIT] = active;
      end
      SEL_INDEX: begin
        readWord[LOG_W-1:0] = targetIndex;
        readWord[ARM_BIT]   = armed;
      end
      SEL_HEAD: readWord[PTR_W-1:0] = swHead;
      SEL_TAIL: readWord[PTR_W-1:0] = swTail;
      default:  readWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             rdData <= '0;
    else if (strobe.readEn) rdData <= readWord;
  end

endmodule

// File: rtl/descRingState.sv
module descRingState
  import ringPkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         REG_AW     = 8,
  parameter int         PTR_W      = 16,
  parameter int         LOG_W      = 8,
  parameter entryKind_t ENTRY_KIND = ENTRY_DESC,
  localparam int        ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              fetchStep,
  input  logic              writeStep,
  output logic              empty,
  output logic              full,
  output logic              active,
  output logic              armed,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] writeAddr
);

  localparam int ENTRY_BYTES = entryBytes(ENTRY_KIND);

  ringStrobe_t strobe;

  ringCtrl #(.REG_AW(REG_AW)) ctrl_i (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .fetchStep (fetchStep),
    .writeStep (writeStep),
    .isEmpty   (empty),
    .isFull    (full),
    .strobe    (strobe)
  );

  ringDatapath #(
    .DATA_W      (DATA_W),
    .PTR_W       (PTR_W),
    .LOG_W       (LOG_W),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (wrData),
    .isEmpty   (empty),
    .isFull    (full),
    .active    (active),
    .armed     (armed),
    .fetchAddr (fetchAddr),
    .writeAddr (writeAddr),
    .rdData    (rdData)
  );

endmodule

// File: rtl/descRingState_chk.sv
module descRingState_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [REG_AW-1:0] wrAddr,
  input logic              rdEn,
  input logic [REG_AW-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              fetchStep,
  input logic              writeStep,
  input logic              empty,
  input logic              full,
  input logic              armed,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] writeAddr
);

  // R2
  base_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == REG_AW'(8'h04) && !fetchStep)
      |=> fetchAddr[DATA_W-1:0] == $past(fetchAddr[DATA_W-1:0]));

  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R5
  index_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdAddr == REG_AW'(8'h0C)) |=> rdData[31] == $past(armed));

  // R6
  fetch_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchStep && empty && !wrEn) |=> ($stable(fetchAddr) && empty));

  // R7
  write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (writeStep && full && !wrEn) |=> ($stable(writeAddr) && full));

endmodule

bind descRingState descRingState_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .fetchStep (fetchStep),
  .writeStep (writeStep),
  .empty     (empty),
  .full      (full),
  .armed     (armed),
  .fetchAddr (fetchAddr),
  .writeAddr (writeAddr)
);

// File: tb/descRingState_tb_top.sv
module descRingState_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        fetchStep = 1'b0;
  logic        writeStep = 1'b0;
  logic        empty, full, active, armed;
  logic [63:0] fetchAddr, writeAddr;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  logic [15:0] mHead = '0, mTail = '0, mIt = '0, mIh = '0;
  int          mLog = 0;
  logic [63:0] mBase = '0;

  always #2 clk = ~clk;

  descRingState dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .fetchStep(fetchStep),
    .writeStep(writeStep), .empty(empty), .full(full), .active(active),
    .armed(armed), .fetchAddr(fetchAddr), .writeAddr(writeAddr)
  );

  function automatic bit mFull();
    if (mLog >= 16) return 1'b0;
    return int'(16'(mIh - mTail)) >= (1 << mLog);
  endfunction

  function automatic logic [63:0] mAddr(logic [15:0] c);
    logic [15:0] mask;
    mask = (mLog >= 16) ? 16'hFFFF : 16'((1 << mLog) - 1);
    return mBase + 64'(c & mask) * 64'd16;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      8'h00: mBase[31:0] = d;
      8'h04: mBase[63:32] = d;
      8'h08: mLog = int'(d[7:0]);
      8'h10: mHead = d[15:0];
      8'h14: mTail = d[15:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic stepW();
    bit ok;
    ok = !mFull();
    @(negedge clk);
    writeStep = 1'b1;
    @(negedge clk);
    writeStep = 1'b0;
    if (ok) mIh++;
    check("R7 full", 64'(full), 64'(mFull()));
    check("R8 writeAddr", writeAddr, mAddr(mIh));
  endtask

  task automatic stepF();
    bit ok;
    ok = (mHead != mIt);
    @(negedge clk);
    fetchStep = 1'b1;
    @(negedge clk);
    fetchStep = 1'b0;
    if (ok) mIt++;
    check("R6 empty", 64'(empty), 64'(mHead == mIt));
    check("R8 fetchAddr", fetchAddr, mAddr(mIt));
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 empty", 64'(empty), 64'd1);
    check("R1 full", 64'(full), 64'd0);
    check("R1 active", 64'(active), 64'd0);
    check("R1 armed", 64'(armed), 64'd0);
    check("R1 fetchAddr", fetchAddr, 64'd0);
    check("R1 writeAddr", writeAddr, 64'd0);
    for (int a = 8; a <= 20; a += 4) begin
      rd(8'(a), d);
      check("R1 readback", 64'(d), 64'd0);
    end

    // R2 base halves
    wr(8'h00, 32'h89AB_C000);
    wr(8'h04, 32'h0000_0012);
    check("R2 base both", fetchAddr, 64'h0000_0012_89AB_C000);
    wr(8'h00, 32'h1111_0000);
    check("R2 low write keeps high", fetchAddr, 64'h0000_0012_1111_0000);
    wr(8'h04, 32'h0000_0003);
    check("R2 high write keeps low", writeAddr, 64'h0000_0003_1111_0000);

    // R3 log word
    wr(8'h08, 32'h8000_0002);
    check("R3 active set", 64'(active), 64'd1);
    rd(8'h08, d);
    check("R3 log readback", 64'(d), 64'h8000_0002);
    wr(8'h08, 32'h0000_0103);
    check("R3 active clear", 64'(active), 64'd0);
    rd(8'h08, d);
    check("R3 log low byte", 64'(d), 64'h0000_0003);

    // R4 index word
    wr(8'h0C, 32'h0000_0007);
    check("R4 no arm", 64'(armed), 64'd0);
    rd(8'h0C, d);
    check("R4 index readback", 64'(d), 64'h0000_0007);
    wr(8'h0C, 32'h8000_0005);
    check("R4 arm set", 64'(armed), 64'd1);
    wr(8'h0C, 32'h0000_0009);
    check("R4 arm sticky", 64'(armed), 64'd1);
    rd(8'h0C, d);
    check("R4 index sticky readback", 64'(d), 64'h8000_0009);

    // R5 pointers and read port
    wr(8'h10, 32'hABCD_1234);
    rd(8'h10, d);
    check("R5 head readback", 64'(d), 64'h1234);
    wr(8'h14, 32'h0000_5678);
    rd(8'h14, d);
    check("R5 tail readback", 64'(d), 64'h5678);
    rd(8'h18, d);
    check("R5 unmapped read", 64'(d), 64'd0);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);

    // R7/R8 fill sweep, ring of 4
    wr(8'h08, 32'h0000_0002);
    check("R7 start", 64'(full), 64'd0);
    for (int i = 0; i < 6; i++) stepW();
    check("R7 capped count", writeAddr, mAddr(16'd4));
    wr(8'h14, 32'h0000_FFFE);
    check("R7 wrap full", 64'(full), 64'(mFull()));
    for (int t = 0; t < 8; t++) begin
      wr(8'h14, 32'(t));
      check("R7 tail sweep", 64'(full), 64'(mFull()));
    end
    wr(8'h14, 32'h3);
    for (int i = 0; i < 4; i++) stepW();

    // R6/R8 fetch side
    check("R6 empty start", 64'(empty), 64'd1);
    stepF();
    wr(8'h10, 32'h3);
    for (int i = 0; i < 4; i++) stepF();
    wr(8'h10, 32'h6);
    for (int i = 0; i < 4; i++) stepF();

    // R7/R8 log size sweep
    for (int lg = 0; lg < 20; lg++) begin
      wr(8'h08, 32'(lg));
      check("R7 log sweep full", 64'(full), 64'(mFull()));
      check("R8 log sweep fetchAddr", fetchAddr, mAddr(mIt));
      check("R8 log sweep writeAddr", writeAddr, mAddr(mIh));
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule